// File: doc/BRIEF.md
# Cache Way Replacement Selector

This block picks which way of a set-associative cache is refilled after a miss. The cache presents the index of the line it is working on together with that line's lock bits. The block answers in the same cycle with the way to evict. It also watches hit events and refill events on the same index, and it keeps a small history per line for the policies that need one. The associativity (1 to 4 ways), the number of lines, the replacement policy and the presence of locking are all set by parameters.

Three policies share one port list:
- **Random** uses a free-running counter.
- **Least-recently-replaced** is a two-way-only scheme. It keeps one bit per line that points at the way not refilled last.
- **Least-recently-used** keeps the access order of the line in 1, 3 or 5 bits for 2, 3 or 4 ways.

When locking is built in, locked ways are skipped. If nothing is left to evict, a flag is raised instead of naming a way.

Top module: `repl_way_sel`

## Requirements
- R1: With one way the victim is always way 0, no history storage is built, and `no_victim` is high only when locking is built in and way 0 is locked.
- R2: The random policy takes its base choice from a counter that starts at 0 after reset and advances on every clock. For 2 ways it counts 0,1,0,...; for 4 ways it counts 0..3; for 3 ways it counts 0,1,2 and skips 3.
- R3: The least-recently-replaced policy is legal only with 2 ways. Its per-line bit resets to 0 (victim way 0). After a refill of way w the line's base victim is the other way. Hits leave it unchanged.
- R4: The least-recently-used policy evicts the least recently accessed way of the indexed line. Both a hit and a refill count as an access. Lines other than the indexed one are not changed.
- R5: The least-recently-used history is 1, 3 or 5 bits per line for 2, 3 or 4 ways. After reset every line orders its ways from way 0 (oldest) to the highest way (newest), so the victim is way 0.
- R6: When a hit and a refill arrive in the same cycle, both are applied to the indexed line. The refilled way becomes the newest, and the hit way becomes the second newest unless it is the same way.
- R7: With locking built in, a locked way is never the victim. The least-recently-used policy picks the oldest unlocked way. The random and least-recently-replaced policies pick the first unlocked way counting upward, with wrap-around, from their base choice.
- R8: If every way of the indexed line is locked, `no_victim` is 1 and `victim_way` is 0.
- R9: With locking not built in (LOCK_EN = 0), the lock bits have no effect on `victim_way`, and `no_victim` stays 0.
- R10: The victim follows `line_idx` and the lock bits in the same cycle. A hit or refill changes the line's selection from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_idx | input | clog2(LINES) | Line index that all events and the selection refer to |
| hit_vld | input | 1 | A hit on `hit_way` of the indexed line |
| hit_way | input | 2 | Way that hit |
| fill_vld | input | 1 | A refill of `fill_way` in the indexed line |
| fill_way | input | 2 | Way being refilled |
| way_lock | input | WAYS | Lock bits of the indexed line, one per way |
| victim_way | output | 2 | Way to evict |
| no_victim | output | 1 | Every way of the indexed line is locked |

## Verification
A hit and a refill can hit the same line in one cycle. For the least-recently-used policy, the order in which the two are applied then decides which way becomes newest. The bench drives the two together on one line with different ways and then reads back the victim of that line, with and without locks on the older ways. A behavioural per-line age list in the bench, touched hit-first then refill, gives the expected victim on every clock.

// File: rtl/rsel_pkg.sv
package rsel_pkg;

  typedef enum logic [1:0] {
    POL_RANDOM = 2'd0,
    POL_LRR    = 2'd1,
    POL_LRU    = 2'd2
  } rsel_policy_e;

  typedef logic [1:0]  way_t;
  typedef way_t [3:0]  order_t;  // entry 0 = first eviction candidate

  function automatic int idx_w(int lines);
    return (lines > 1) ? $clog2(lines) : 1;
  endfunction

  function automatic int hist_w(int pol, int ways);
    if (ways < 2) return 1;
    if (pol == int'(POL_LRU)) return (ways == 2) ? 1 : (ways == 3) ? 3 : 5;
    return 1;
  endfunction

  // Rotating candidate list starting at base.
  function automatic order_t cyc_order(int ways, way_t base);
    order_t o;
    o = '0;
    for (int i = 0; i < 4; i++)
      if (i < ways) o[i] = way_t'((int'(base) + i) % ways);
    return o;
  endfunction

  // History code -> age list, oldest first.
  function automatic order_t lru_decode(int ways, logic [4:0] code);
    order_t     o;
    int         r0, r1, r2, k, d0, d1, d2, dsel;
    logic [3:0] used;
    o = '0;
    case (ways)
      2: begin
        o[0] = way_t'(code[0]);
        o[1] = way_t'(!code[0]);
      end
      3: begin
        // bit0: 0 newer than 1, bit1: 0 newer than 2, bit2: 1 newer than 2
        r0 = int'(code[0]) + int'(code[1]);
        r1 = int'(!code[0]) + int'(code[2]);
        r2 = int'(!code[1]) + int'(!code[2]);
        o[r0] = 2'd0;
        o[r1] = 2'd1;
        o[r2] = 2'd2;
      end
      4: begin
        d0 = int'(code) / 6;
        d1 = (int'(code) % 6) / 2;
        d2 = int'(code) % 2;
        used = '0;
        for (int s = 0; s < 3; s++) begin
          dsel = (s == 0) ? d0 : (s == 1) ? d1 : d2;
          k = 0;
          for (int w = 0; w < 4; w++) begin
            if (!used[w]) begin
              if (k == dsel) begin
                o[s]    = way_t'(w);
                used[w] = 1'b1;
              end
              k++;
            end
          end
        end
        for (int w = 0; w < 4; w++)
          if (!used[w]) o[3] = way_t'(w);
      end
      default: o = '0;
    endcase
    return o;
  endfunction

  // Age list -> history code.
  function automatic logic [4:0] lru_encode(int ways, order_t o);
    int pos [4];
    int d1, d2;
    logic [4:0] c;
    c = '0;
    pos = '{0, 0, 0, 0};
    case (ways)
      2: c = {4'b0, o[0][0]};
      3: begin
        for (int i = 0; i < 3; i++) pos[o[i]] = i;
        c = {2'b0, pos[1] > pos[2], pos[0] > pos[2], pos[0] > pos[1]};
      end
      4: begin
        d1 = 0;
        d2 = 0;
        for (int w = 0; w < 4; w++) begin
          if (way_t'(w) < o[1] && way_t'(w) != o[0]) d1++;
          if (way_t'(w) < o[2] && way_t'(w) != o[0] && way_t'(w) != o[1]) d2++;
        end
        c = 5'(int'(o[0]) * 6 + d1 * 2 + d2);
      end
      default: c = '0;
    endcase
    return c;
  endfunction

  // Move way w to the newest slot.
  function automatic order_t lru_touch(int ways, order_t o, way_t w);
    order_t n;
    int p;
    p = 0;
    for (int i = 0; i < 4; i++)
      if (i < ways && o[i] == w) p = i;
    n = o;
    for (int i = 0; i < 3; i++)
      if (i >= p && i < ways - 1) n[i] = o[i+1];
    n[ways-1] = w;
    return n;
  endfunction

endpackage

// File: rtl/rsel_hist_mem.sv
module rsel_hist_mem #(
  parameter int LINES = 16,
  parameter int HW    = 5,
  localparam int IW   = rsel_pkg::idx_w(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] idx,
  input  logic          wr_en,
  input  logic [HW-1:0] wr_data,
  output logic [HW-1:0] rd_data
);

  logic [HW-1:0] mem_q [LINES];
  logic [HW-1:0] mem_d [LINES];

  always_comb begin
    mem_d = mem_q;
    if (wr_en) mem_d[idx] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < LINES; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign rd_data = mem_q[idx];

endmodule

// File: rtl/rsel_rand_ctr.sv
module rsel_rand_ctr #(
  parameter int WAYS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  output rsel_pkg::way_t    value
);
  import rsel_pkg::*;

  way_t cnt_q, cnt_d;
  logic cnt_en;

  assign cnt_en = 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = (cnt_q == way_t'(WAYS - 1)) ? '0 : cnt_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign value = cnt_q;

endmodule

// File: rtl/rsel_pick.sv
module rsel_pick #(
  parameter int WAYS    = 4,
  parameter bit LOCK_EN = 1'b1
) (
  input  rsel_pkg::order_t  order,
  input  logic [WAYS-1:0]   lock,
  output rsel_pkg::way_t    victim,
  output logic              none
);
  import rsel_pkg::*;

  logic [3:0] lk4;
  way_t       sel;
  logic       miss;

  assign lk4 = 4'(lock);

  always_comb begin
    sel  = '0;
    miss = 1'b1;
    for (int i = 0; i < WAYS; i++) begin
      if (miss && !(LOCK_EN && lk4[order[i]])) begin
        sel  = order[i];
        miss = 1'b0;
      end
    end
  end

  assign victim = miss ? '0 : sel;
  assign none   = miss;

endmodule

// File: rtl/repl_way_sel.sv
module repl_way_sel #(
  parameter int                     WAYS    = 4,
  parameter int                     LINES   = 16,
  parameter rsel_pkg::rsel_policy_e POLICY  = rsel_pkg::POL_LRU,
  parameter bit                     LOCK_EN = 1'b1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [rsel_pkg::idx_w(LINES)-1:0]   line_idx,
  input  logic                                hit_vld,
  input  logic [1:0]                          hit_way,
  input  logic                                fill_vld,
  input  logic [1:0]                          fill_way,
  input  logic [WAYS-1:0]                     way_lock,
  output logic [1:0]                          victim_way,
  output logic                                no_victim
);
  import rsel_pkg::*;

  localparam int IW   = idx_w(LINES);
  localparam int HW   = hist_w(int'(POLICY), WAYS);
  localparam bit KEEP = (WAYS > 1) && (POLICY != POL_RANDOM);

  order_t pref;

  if (KEEP) begin : g_hist
    logic [HW-1:0] cur, nxt;
    logic          we;

    rsel_hist_mem #(.LINES(LINES), .HW(HW)) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx     (line_idx),
      .wr_en   (we),
      .wr_data (nxt),
      .rd_data (cur)
    );

    if (POLICY == POL_LRU) begin : g_lru
      order_t o_cur, o_hit, o_fill;
      always_comb begin
        o_cur  = lru_decode(WAYS, 5'(cur));
        o_hit  = hit_vld  ? lru_touch(WAYS, o_cur, hit_way)  : o_cur;
        o_fill = fill_vld ? lru_touch(WAYS, o_hit, fill_way) : o_hit;
        nxt    = HW'(lru_encode(WAYS, o_fill));
        we     = hit_vld | fill_vld;
      end
      assign pref = o_cur;
    end else begin : g_lrr
      assign nxt  = HW'(~fill_way[0]);
      assign we   = fill_vld;
      assign pref = cyc_order(WAYS, way_t'(cur[0]));
    end
  end else begin : g_nohist
    way_t base;
    if (WAYS > 1) begin : g_rnd
      rsel_rand_ctr #(.WAYS(WAYS)) u_rnd (
        .clk   (clk),
        .rst_n (rst_n),
        .value (base)
      );
    end else begin : g_one
      assign base = '0;
    end
    assign pref = cyc_order(WAYS, base);
  end

  rsel_pick #(.WAYS(WAYS), .LOCK_EN(LOCK_EN)) u_pick (
    .order  (pref),
    .lock   (way_lock),
    .victim (victim_way),
    .none   (no_victim)
  );

endmodule

// File: rtl/rsel_chk.sv
module rsel_chk #(
  parameter int                     WAYS    = 4,
  parameter int                     LINES   = 16,
  parameter rsel_pkg::rsel_policy_e POLICY  = rsel_pkg::POL_LRU,
  parameter bit                     LOCK_EN = 1'b1
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic [rsel_pkg::idx_w(LINES)-1:0]   line_idx,
  input logic                                hit_vld,
  input logic [1:0]                          hit_way,
  input logic                                fill_vld,
  input logic [1:0]                          fill_way,
  input logic [WAYS-1:0]                     way_lock,
  input logic [1:0]                          victim_way,
  input logic                                no_victim
);
  import rsel_pkg::*;

  logic       past_ok;
  logic [3:0] lk4;
  assign lk4 = 4'(way_lock);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  initial begin : c_cfg_r3
    assert (POLICY != POL_LRR || WAYS == 2)
      else $error("least-recently-replaced needs exactly 2 ways");
  end

  p_victim_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(victim_way) < WAYS);

  p_victim_unlocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (LOCK_EN && !no_victim) |-> !lk4[victim_way]);

  p_none_all_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    no_victim == (LOCK_EN && (&way_lock)));

  p_none_way0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    no_victim |-> victim_way == 2'd0);

  if (POLICY != POL_RANDOM && WAYS > 1) begin : g_hist_chk
    p_fill_not_victim_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(fill_vld) && line_idx == $past(line_idx) && way_lock == '0)
        |-> victim_way != $past(fill_way));
  end

  if (POLICY == POL_LRR) begin : g_lrr_chk
    p_hit_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(fill_vld) && line_idx == $past(line_idx) &&
       way_lock == $past(way_lock)) |-> victim_way == $past(victim_way));
  end

  if (POLICY == POL_RANDOM && WAYS > 1) begin : g_rnd_chk
    p_rand_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && (!LOCK_EN || (way_lock == '0 && $past(way_lock) == '0)))
        |-> victim_way == (($past(victim_way) == 2'(WAYS - 1)) ? 2'd0 : $past(victim_way) + 2'd1));
  end

endmodule

bind repl_way_sel rsel_chk #(
  .WAYS(WAYS), .LINES(LINES), .POLICY(POLICY), .LOCK_EN(LOCK_EN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .line_idx   (line_idx),
  .hit_vld    (hit_vld),
  .hit_way    (hit_way),
  .fill_vld   (fill_vld),
  .fill_way   (fill_way),
  .way_lock   (way_lock),
  .victim_way (victim_way),
  .no_victim  (no_victim)
);

// File: tb/repl_way_sel_tb_top.sv
module repl_way_sel_tb_top;
  import rsel_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] idx;
  logic       hv, fv;
  logic [1:0] hw, fw;
  logic [3:0] lk;

  int checks = 0;
  int errors = 0;
  int phase  = 0;
  bit cmp_on = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  logic [1:0] hw3, fw3, hw2, fw2;
  assign hw3 = (hw == 2'd3) ? 2'd2 : hw;
  assign fw3 = (fw == 2'd3) ? 2'd2 : fw;
  assign hw2 = {1'b0, hw[0]};
  assign fw2 = {1'b0, fw[0]};

  logic [1:0] v_lru4, v_lru3, v_lrr2, v_rnd3, v_rnd4n, v_one;
  logic       n_lru4, n_lru3, n_lrr2, n_rnd3, n_rnd4n, n_one;

  repl_way_sel dut_i (
    .clk(clk), .rst_n(rst_n), .line_idx(idx), .hit_vld(hv), .hit_way(hw),
    .fill_vld(fv), .fill_way(fw), .way_lock(lk), .victim_way(v_lru4), .no_victim(n_lru4));

  repl_way_sel #(.WAYS(3), .POLICY(POL_LRU)) u_lru3 (
    .clk(clk), .rst_n(rst_n), .line_idx(idx), .hit_vld(hv), .hit_way(hw3),
    .fill_vld(fv), .fill_way(fw3), .way_lock(lk[2:0]), .victim_way(v_lru3), .no_victim(n_lru3));

  repl_way_sel #(.WAYS(2), .POLICY(POL_LRR)) u_lrr2 (
    .clk(clk), .rst_n(rst_n), .line_idx(idx), .hit_vld(hv), .hit_way(hw2),
    .fill_vld(fv), .fill_way(fw2), .way_lock(lk[1:0]), .victim_way(v_lrr2), .no_victim(n_lrr2));

  repl_way_sel #(.WAYS(3), .POLICY(POL_RANDOM)) u_rnd3 (
    .clk(clk), .rst_n(rst_n), .line_idx(idx), .hit_vld(hv), .hit_way(hw3),
    .fill_vld(fv), .fill_way(fw3), .way_lock(lk[2:0]), .victim_way(v_rnd3), .no_victim(n_rnd3));

  repl_way_sel #(.WAYS(4), .POLICY(POL_RANDOM), .LOCK_EN(1'b0)) u_rnd4n (
    .clk(clk), .rst_n(rst_n), .line_idx(idx), .hit_vld(hv), .hit_way(hw),
    .fill_vld(fv), .fill_way(fw), .way_lock(lk), .victim_way(v_rnd4n), .no_victim(n_rnd4n));

  repl_way_sel #(.WAYS(1)) u_one (
    .clk(clk), .rst_n(rst_n), .line_idx(idx), .hit_vld(hv), .hit_way(2'd0),
    .fill_vld(fv), .fill_way(2'd0), .way_lock(lk[0]), .victim_way(v_one), .no_victim(n_one));

  // Behavioural reference: age lists (oldest first), replaced bits, counters.
  int ord [2][16][4];
  int lrr [16];
  int rc3, rc4;
  bit both_prev, ev_prev;

  task automatic touch(int m, int l, int w);
    int n = (m == 0) ? 4 : 3;
    int p = 0;
    for (int i = 0; i < n; i++) if (ord[m][l][i] == w) p = i;
    for (int i = p; i < n - 1; i++) ord[m][l][i] = ord[m][l][i+1];
    ord[m][l][n-1] = w;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < 16; l++) begin
        for (int i = 0; i < 4; i++) begin
          ord[0][l][i] = i;
          ord[1][l][i] = i;
        end
        lrr[l] = 0;
      end
      rc3 = 0; rc4 = 0; both_prev = 0; ev_prev = 0;
    end else begin
      if (hv) begin
        touch(0, int'(idx), int'(hw));
        touch(1, int'(idx), int'(hw3));
      end
      if (fv) begin
        touch(0, int'(idx), int'(fw));
        touch(1, int'(idx), int'(fw3));
        lrr[idx] = 1 - int'(fw[0]);
      end
      rc3 = (rc3 + 1) % 3;
      rc4 = (rc4 + 1) % 4;
      both_prev = hv && fv;
      ev_prev   = hv || fv;
    end
  end

  function automatic int pick(int n, int a0, int a1, int a2, int a3, int lkb, bit en);
    int a [4];
    a = '{a0, a1, a2, a3};
    for (int i = 0; i < n; i++)
      if (!(en && ((lkb >> a[i]) & 1) == 1)) return a[i];
    return -1;
  endfunction

  function automatic string tg(string base, int r, int lkrel, string lockt);
    if (r < 0) return "R8";
    if (lkrel != 0) return lockt;
    return base;
  endfunction

  task automatic chk(string tag, string nm, int av, int an, int r);
    int ev = (r < 0) ? 0 : r;
    int en = (r < 0) ? 1 : 0;
    checks++;
    if (av != ev || an != en) begin
      errors++;
      $display("FAIL %s %s: victim=%0d none=%0d, expected victim=%0d none=%0d",
               tag, nm, av, an, ev, en);
    end
  endtask

  always @(negedge clk) begin : cmp_blk
    int l, r, lki;
    string b4;
    if (rst_n && cmp_on) begin
      l   = int'(idx);
      lki = int'(lk);
      b4  = (phase == 1) ? "R5" : both_prev ? "R6" : ev_prev ? "R10" : "R4";
      r = pick(4, ord[0][l][0], ord[0][l][1], ord[0][l][2], ord[0][l][3], lki, 1);
      chk(tg(b4, r, lki, "R7"), "lru4", int'(v_lru4), int'(n_lru4), r);
      r = pick(3, ord[1][l][0], ord[1][l][1], ord[1][l][2], 0, lki & 7, 1);
      chk(tg((phase == 1) ? "R5" : "R4", r, lki & 7, "R7"), "lru3", int'(v_lru3), int'(n_lru3), r);
      r = pick(2, lrr[l], 1 - lrr[l], 0, 0, lki & 3, 1);
      chk(tg("R3", r, lki & 3, "R7"), "lrr2", int'(v_lrr2), int'(n_lrr2), r);
      r = pick(3, rc3, (rc3 + 1) % 3, (rc3 + 2) % 3, 0, lki & 7, 1);
      chk(tg("R2", r, lki & 7, "R7"), "rnd3", int'(v_rnd3), int'(n_rnd3), r);
      r = pick(4, rc4, (rc4 + 1) % 4, (rc4 + 2) % 4, (rc4 + 3) % 4, lki, 0);
      chk(tg("R2", r, lki, "R9"), "rnd4 nolock", int'(v_rnd4n), int'(n_rnd4n), r);
      r = pick(1, 0, 0, 0, 0, lki & 1, 1);
      chk(tg("R1", r, 0, "R1"), "one way", int'(v_one), int'(n_one), r);
    end
  end

  task automatic drive(int l, bit h, int hwy, bit f, int fwy, int lkv);
    @(posedge clk);
    #1;
    idx = 4'(l); hv = h; hw = 2'(hwy); fv = f; fw = 2'(fwy); lk = 4'(lkv);
  endtask

  initial begin : main
    rst_n = 1'b0;
    idx = '0; hv = 0; hw = '0; fv = 0; fw = '0; lk = '0;
    repeat (2) @(negedge clk);
    chk("R5", "lru4 in reset", int'(v_lru4), int'(n_lru4), 0);
    chk("R2", "rnd3 in reset", int'(v_rnd3), int'(n_rnd3), 0);
    @(negedge clk);
    rst_n  = 1'b1;
    cmp_on = 1'b1;
    // R5: reset order of every line
    phase = 1;
    for (int l = 0; l < 16; l++) drive(l, 0, 0, 0, 0, 0);
    phase = 0;
    // R6: simultaneous hit and refill on one line
    drive(5, 1, 1, 1, 3, 0);
    drive(5, 0, 0, 0, 0, 0);
    drive(5, 0, 0, 0, 0, 1);      // R7: oldest locked
    drive(5, 1, 2, 1, 2, 3);      // R6: same way on both
    drive(5, 0, 0, 0, 0, 0);
    drive(5, 0, 0, 0, 0, 15);     // R8
    drive(4, 0, 0, 0, 0, 0);      // R4: other line untouched
    // R3: refill flips, hit ignored
    drive(6, 0, 0, 1, 0, 0);
    drive(6, 1, 1, 0, 0, 0);
    drive(6, 1, 0, 0, 0, 0);
    drive(6, 0, 0, 1, 1, 0);
    drive(6, 0, 0, 0, 0, 2);
    // mixed traffic
    for (int n = 0; n < 4000; n++) begin
      drive(($urandom % 2) ? int'($urandom % 4) : int'($urandom % 16),
            bit'($urandom % 2), int'($urandom % 4),
            ($urandom % 3) == 0, int'($urandom % 4),
            (($urandom % 5) == 0) ? int'($urandom % 16) : 0);
    end
    drive(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog: actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule